// File: doc/BRIEF.md
# Weight-Stationary Matrix Unit with Shadow Tile

This block multiplies a stream of signed input vectors by a square tile of signed weights that stays fixed in the array for the whole batch. It keeps two weight tiles. The active tile feeds the multipliers. The shadow tile is filled one row per cycle from an internal staging queue, and that filling continues while the active tile computes. Weight rows enter the staging queue through a valid/ready push port. The queue can hold several whole tiles, so weight fetch is decoupled from compute.

Input vectors arrive on a valid/ready port, one per cycle. Each vector carries four things: an accumulator row address, an accumulate-or-overwrite flag, a last-of-batch marker and a swap request. A swap request on the first vector of a batch copies the shadow tile into the active tile in the same cycle that vector is accepted. The array stalls while the shadow tile is still loading, or when no tile has been made active yet. Each result vector is either written into a bank of wide accumulators or added to what that bank row already holds. Any bank row can be read combinationally.

Top module: `ws_matrix_unit`

## Requirements
- R1: After reset, every accumulator row reads as zero, `wq_ready` is high, and no weight tile is active.
- R2: The shadow tile takes one row per cycle from the staging queue, in push order. A row pushed at clock edge e enters the shadow tile at edge e+1. With N rows pushed on consecutive edges starting at e0, the shadow tile is complete after edge e0+N.
- R3: The staging queue holds 4·N weight rows on top of the N rows the shadow tile holds. With the shadow tile empty and no swap, exactly 5·N consecutive pushes are accepted, and then `wq_ready` stays low.
- R4: For input x and active tile W, output column j is the signed sum over i of x[i]·W[i][j]. Element k of `act_vec`, of a weight row, and of `rd_data` sits at bit offset k·8, k·8 and k·32 respectively. Row i of a tile is the i-th row pushed for that tile.
- R5: When `act_accum` is 1, the result is added to the addressed accumulator row. When it is 0, the result replaces that row. This holds for back-to-back vectors that use the same address.
- R6: Each column of a product is an 8×8-bit signed multiply. Sums use 32-bit accumulators that wrap modulo 2^32.
- R7: A swap request takes effect only on the first vector of a batch. The first vector is the first one after reset or the first one after a vector with `act_last` set. On any other vector the request is ignored, causes no stall, and the current tile stays in use.
- R8: A swap request on the first vector of a batch holds `act_ready` low until the shadow tile is complete. The vector then uses the new tile.
- R9: While no tile is active, a vector without an acceptable swap request is not accepted.
- R10: When weights are available, the vectors of a batch are accepted one per cycle with no bubbles.
- R11: A vector accepted at edge t is visible on `rd_data` after edge t+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wq_valid | input | 1 | A weight row is offered |
| wq_ready | output | 1 | The staging queue can take a row |
| wq_row | input | N·DW | One weight row, element k at bits k·DW |
| act_valid | input | 1 | An input vector is offered |
| act_ready | output | 1 | The array accepts the vector this cycle |
| act_vec | input | N·DW | Input vector, element k at bits k·DW |
| act_last | input | 1 | This vector ends its batch |
| act_swap | input | 1 | Make the shadow tile active before this vector (first vector only) |
| act_accum | input | 1 | 1: add to the accumulator row; 0: overwrite it |
| act_addr | input | log2(ACC_ROWS) | Accumulator row address |
| rd_addr | input | log2(ACC_ROWS) | Read address of the accumulator bank |
| rd_data | output | N·AW | Accumulator row, column k at bits k·AW |

## Verification
A wrong shadow row index or a swap that lands mid-batch would not be flagged directly. It would show up as a wrong column sum at the accumulator read port two edges after the affected vector is accepted. A broken load counter or a broken queue occupancy would show up earlier, as `act_ready` or `wq_ready` changing one cycle too soon or too late against the push count. The bench therefore samples those ready lines at each edge of the load. It also reads back every accumulator row a batch has touched, and it checks that wraparound occurs exactly at the 2^31 boundary.

// File: rtl/mxu_pkg.sv
package mxu_pkg;

   typedef enum logic [0:0] {
      WR_OVERWRITE = 1'b0,
      WR_ACCUM     = 1'b1
   } mxu_wmode_e;

   typedef struct packed {
      logic       vld;
      mxu_wmode_e mode;
   } mxu_tag_t;

endpackage

// File: rtl/mxu_wfifo.sv
module mxu_wfifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_valid,
   output logic         push_ready,
   input  logic [W-1:0] push_data,
   output logic         pop_valid,
   input  logic         pop_ready,
   output logic [W-1:0] pop_data
);
   localparam int  PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH == (1 << PW));

   if (DEPTH < 2) begin : g_bad_depth
      $error("mxu_wfifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt;
   logic          push, pop;

   if (POW2) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_mod
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign push_ready = (cnt != CW'(DEPTH));
   assign pop_valid  = (cnt != '0);
   assign pop_data   = mem[rd_ptr];
   assign push       = push_valid && push_ready;
   assign pop        = pop_valid && pop_ready;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R3
   fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // R3
   fifo_full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(DEPTH)) && !pop |=> $stable(wr_ptr));

endmodule

// File: rtl/mxu_wbuf.sv
module mxu_wbuf #(
   parameter int N  = 4,
   parameter int DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   output logic              ld_ready,
   input  logic [N*DW-1:0]   ld_row,
   input  logic              swap,
   output logic              shd_full,
   output logic              tile_active,
   output logic [N*N*DW-1:0] eff_w
);
   localparam int ROW_W = N * DW;
   localparam int CW    = $clog2(N + 1);

   logic [N-1:0][ROW_W-1:0] w_act, w_shd;
   logic [CW-1:0]           cnt;
   logic                    ld_fire;

   assign shd_full = (cnt == CW'(N));
   assign ld_ready = !shd_full;
   assign ld_fire  = ld_valid && ld_ready;
   assign eff_w    = swap ? w_shd : w_act;

   for (genvar r = 0; r < N; r++) begin : g_shd_row
      always_ff @(posedge clk) begin
         if (ld_fire && (cnt == CW'(r))) w_shd[r] <= ld_row;
      end
   end

   always_ff @(posedge clk) begin
      if (swap) w_act <= w_shd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt         <= '0;
         tile_active <= 1'b0;
      end else if (swap) begin
         cnt         <= '0;
         tile_active <= 1'b1;
      end else if (ld_fire) begin
         cnt         <= cnt + 1'b1;
      end
   end

   // R8
   swap_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap |-> shd_full);

   // R2
   shadow_empties_on_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> (cnt == '0) && tile_active);

endmodule

// File: rtl/mxu_array.sv
module mxu_array
   import mxu_pkg::*;
#(
   parameter int N     = 4,
   parameter int DW    = 8,
   parameter int AW    = 32,
   parameter int ABITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  mxu_wmode_e        in_mode,
   input  logic [ABITS-1:0]  in_addr,
   input  logic [N*DW-1:0]   in_x,
   input  logic [N*N*DW-1:0] in_w,
   output mxu_tag_t          out_tag,
   output logic [ABITS-1:0]  out_addr,
   output logic [N*AW-1:0]   out_sum
);
   localparam int PW = 2 * DW;

   logic signed [PW-1:0] prod_q [N][N];

   for (genvar gi = 0; gi < N; gi++) begin : g_row
      for (genvar gj = 0; gj < N; gj++) begin : g_mac
         logic signed [DW-1:0] xa, wb;
         assign xa = in_x[gi*DW +: DW];
         assign wb = in_w[(gi*N + gj)*DW +: DW];
         always_ff @(posedge clk) begin
            if (in_vld) prod_q[gi][gj] <= xa * wb;
         end
      end
   end

   for (genvar gj = 0; gj < N; gj++) begin : g_col
      logic [AW-1:0] col_s;
      always_comb begin
         col_s = '0;
         for (int i = 0; i < N; i++) begin
            col_s = col_s + {{(AW-PW){prod_q[i][gj][PW-1]}}, prod_q[i][gj]};
         end
      end
      assign out_sum[gj*AW +: AW] = col_s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_tag  <= '{vld: 1'b0, mode: WR_OVERWRITE};
         out_addr <= '0;
      end else begin
         out_tag  <= '{vld: in_vld, mode: in_mode};
         if (in_vld) out_addr <= in_addr;
      end
   end

   // R10
   array_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_tag.vld && (out_addr == $past(in_addr)));

endmodule

// File: rtl/mxu_accbank.sv
module mxu_accbank
   import mxu_pkg::*;
#(
   parameter int N    = 4,
   parameter int AW   = 32,
   parameter int ROWS = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  mxu_tag_t                 wr_tag,
   input  logic [$clog2(ROWS)-1:0]  wr_addr,
   input  logic [N*AW-1:0]          wr_sum,
   input  logic [$clog2(ROWS)-1:0]  rd_addr,
   output logic [N*AW-1:0]          rd_data
);
   localparam int ABITS = $clog2(ROWS);

   if (ROWS != (1 << ABITS)) begin : g_bad_rows
      $error("mxu_accbank: ROWS must be a power of two");
   end

   logic [N*AW-1:0] bank [ROWS];
   logic [N*AW-1:0] nxt_row;

   for (genvar gj = 0; gj < N; gj++) begin : g_col
      logic [AW-1:0] old_v, add_v;
      assign old_v = bank[wr_addr][gj*AW +: AW];
      assign add_v = wr_sum[gj*AW +: AW];
      assign nxt_row[gj*AW +: AW] = (wr_tag.mode == WR_ACCUM) ? old_v + add_v : add_v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) bank[r] <= '0;
      end else if (wr_tag.vld) begin
         bank[wr_addr] <= nxt_row;
      end
   end

   assign rd_data = bank[rd_addr];

   // R5
   overwrite_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tag.vld && (wr_tag.mode == WR_OVERWRITE) |=> bank[$past(wr_addr)] == $past(wr_sum));

   // R11
   idle_bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_tag.vld |=> $stable(bank[$past(wr_addr)]));

endmodule

// File: rtl/ws_matrix_unit.sv
module ws_matrix_unit
   import mxu_pkg::*;
#(
   parameter int N          = 4,
   parameter int DW         = 8,
   parameter int AW         = 32,
   parameter int FIFO_TILES = 4,
   parameter int ACC_ROWS   = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wq_valid,
   output logic                        wq_ready,
   input  logic [N*DW-1:0]             wq_row,
   input  logic                        act_valid,
   output logic                        act_ready,
   input  logic [N*DW-1:0]             act_vec,
   input  logic                        act_last,
   input  logic                        act_swap,
   input  logic                        act_accum,
   input  logic [$clog2(ACC_ROWS)-1:0] act_addr,
   input  logic [$clog2(ACC_ROWS)-1:0] rd_addr,
   output logic [N*AW-1:0]             rd_data
);
   localparam int ROW_W  = N * DW;
   localparam int ABITS  = $clog2(ACC_ROWS);
   localparam int FDEPTH = FIFO_TILES * N;

   if (N < 1 || FIFO_TILES < 1) begin : g_bad_shape
      $error("ws_matrix_unit: N and FIFO_TILES must be positive");
   end
   if (AW < 2*DW + $clog2(N)) begin : g_bad_acc
      $error("ws_matrix_unit: AW too narrow for one vector sum");
   end

   logic              q_valid, q_ready;
   logic [ROW_W-1:0]  q_row;
   logic              shd_full, tile_active;
   logic [N*N*DW-1:0] eff_w;
   logic              first_q, want_swap, swap_fire, fire;
   mxu_tag_t          arr_tag;
   logic [ABITS-1:0]  arr_addr;
   logic [N*AW-1:0]   arr_sum;

   assign want_swap = act_swap && first_q;
   assign act_ready = want_swap ? shd_full : tile_active;
   assign fire      = act_valid && act_ready;
   assign swap_fire = fire && want_swap;

   always_ff @(posedge clk) begin
      if (!rst_n)    first_q <= 1'b1;
      else if (fire) first_q <= act_last;
   end

   mxu_wfifo #(.W(ROW_W), .DEPTH(FDEPTH)) u_wq (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (wq_valid),
      .push_ready (wq_ready),
      .push_data  (wq_row),
      .pop_valid  (q_valid),
      .pop_ready  (q_ready),
      .pop_data   (q_row)
   );

   mxu_wbuf #(.N(N), .DW(DW)) u_wbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_valid    (q_valid),
      .ld_ready    (q_ready),
      .ld_row      (q_row),
      .swap        (swap_fire),
      .shd_full    (shd_full),
      .tile_active (tile_active),
      .eff_w       (eff_w)
   );

   mxu_array #(.N(N), .DW(DW), .AW(AW), .ABITS(ABITS)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (fire),
      .in_mode  (act_accum ? WR_ACCUM : WR_OVERWRITE),
      .in_addr  (act_addr),
      .in_x     (act_vec),
      .in_w     (eff_w),
      .out_tag  (arr_tag),
      .out_addr (arr_addr),
      .out_sum  (arr_sum)
   );

   mxu_accbank #(.N(N), .AW(AW), .ROWS(ACC_ROWS)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_tag  (arr_tag),
      .wr_addr (arr_addr),
      .wr_sum  (arr_sum),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   // R7
   swap_only_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !act_last |=> !first_q);

   // R9
   no_tile_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !tile_active |-> swap_fire);

   // R11
   result_two_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> arr_tag.vld);

endmodule

// File: tb/ws_matrix_unit_tb.sv
module ws_matrix_unit_tb;
   localparam int N  = 4;
   localparam int AW = 32;
   localparam int ROWS = 16;

   typedef struct packed {
      logic [31:0] x;
      logic [3:0]  addr;
      logic        acc;
      logic        last;
      logic        swap;
   } vec_t;

   function automatic logic [31:0] pk(int a, int b, int c, int d);
      return {d[7:0], c[7:0], b[7:0], a[7:0]};
   endfunction

   localparam vec_t TBL [10] = '{
      '{pk(1, 2, 3, 4),       4'd0, 1'b0, 1'b0, 1'b1},
      '{pk(-1, -2, -3, -4),   4'd1, 1'b0, 1'b0, 1'b0},
      '{pk(127, -128, 5, 0),  4'd2, 1'b0, 1'b0, 1'b0},
      '{pk(2, 0, 0, 0),       4'd0, 1'b1, 1'b0, 1'b0},
      '{pk(0, 0, 0, 0),       4'd3, 1'b0, 1'b0, 1'b1},
      '{pk(10, -20, 30, -40), 4'd3, 1'b1, 1'b1, 1'b0},
      '{pk(3, 3, 3, 3),       4'd4, 1'b0, 1'b1, 1'b0},
      '{pk(1, 1, 1, 1),       4'd0, 1'b1, 1'b0, 1'b1},
      '{pk(-5, 6, -7, 8),     4'd1, 1'b1, 1'b0, 1'b0},
      '{pk(-128, -128, -128, -128), 4'd5, 1'b0, 1'b1, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wq_valid = 1'b0;
   logic        wq_ready;
   logic [31:0] wq_row = '0;
   logic        act_valid = 1'b0;
   logic        act_ready;
   logic [31:0] act_vec = '0;
   logic        act_last = 1'b0, act_swap = 1'b0, act_accum = 1'b0;
   logic [3:0]  act_addr = '0;
   logic [3:0]  rd_addr = '0;
   logic [N*AW-1:0] rd_data;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   logic signed [7:0] tw [2][N][N];
   int          cur_tile = -1;
   int          next_tile = 0;
   bit          m_first = 1'b1;
   logic [31:0] m_acc [ROWS][N];

   ws_matrix_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .wq_valid(wq_valid), .wq_ready(wq_ready), .wq_row(wq_row),
      .act_valid(act_valid), .act_ready(act_ready), .act_vec(act_vec),
      .act_last(act_last), .act_swap(act_swap), .act_accum(act_accum),
      .act_addr(act_addr), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, cycle %0d expected below 150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] tile_row(int t, int i);
      return pk(tw[t][i][0], tw[t][i][1], tw[t][i][2], tw[t][i][3]);
   endfunction

   task automatic model_vec(vec_t v);
      if (m_first && v.swap) begin
         cur_tile = next_tile;
         next_tile++;
      end
      for (int j = 0; j < N; j++) begin
         int s = 0;
         for (int i = 0; i < N; i++) begin
            int xi = $signed(v.x[i*8 +: 8]);
            s += xi * int'(tw[cur_tile][i][j]);
         end
         m_acc[v.addr][j] = v.acc ? m_acc[v.addr][j] + 32'(s) : 32'(s);
      end
      m_first = v.last;
   endtask

   task automatic drive(vec_t v);
      act_valid = 1'b1;
      act_vec   = v.x;
      act_addr  = v.addr;
      act_accum = v.acc;
      act_last  = v.last;
      act_swap  = v.swap;
   endtask

   // one vector; no_bubble asks for act_ready high at once (R10)
   task automatic send(vec_t v, bit no_bubble);
      @(negedge clk);
      drive(v);
      #1;
      if (no_bubble) chk("R10 no bubble", 32'(act_ready), 32'd1);
      while (!act_ready) @(negedge clk);
      @(posedge clk);
      model_vec(v);
   endtask

   task automatic idle(int n);
      @(negedge clk);
      act_valid = 1'b0;
      wq_valid  = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic read_cmp(string req, int a);
      @(negedge clk);
      rd_addr = 4'(a);
      #1;
      for (int j = 0; j < N; j++) chk(req, rd_data[j*AW +: AW], m_acc[a][j]);
   endtask

   task automatic push_tile(int t);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         wq_valid = 1'b1;
         wq_row   = tile_row(t, i);
         @(posedge clk);
      end
      @(negedge clk);
      wq_valid = 1'b0;
   endtask

   initial begin
      // tile A
      tw[0][0] = '{8'sd1, -8'sd2, 8'sd3, -8'sd4};
      tw[0][1] = '{8'sd5, 8'sd6, -8'sd7, 8'sd8};
      tw[0][2] = '{-8'sd9, 8'sd10, 8'sd11, -8'sd12};
      tw[0][3] = '{8'sd13, -8'sd14, 8'sd15, 8'sd16};
      // tile B, column 0 all -128
      tw[1][0] = '{-8'sd128, 8'sd1, 8'sd2, 8'sd3};
      tw[1][1] = '{-8'sd128, -8'sd1, 8'sd0, 8'sd4};
      tw[1][2] = '{-8'sd128, 8'sd2, -8'sd3, 8'sd5};
      tw[1][3] = '{-8'sd128, 8'sd0, 8'sd7, -8'sd6};
      for (int r = 0; r < ROWS; r++)
         for (int j = 0; j < N; j++) m_acc[r][j] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 wq_ready", 32'(wq_ready), 32'd1);
      chk("R1 act_ready", 32'(act_ready), 32'd0);
      read_cmp("R1 bank zero", 0);
      read_cmp("R1 bank zero", 15);

      // R9: no tile active, plain vector stalls
      @(negedge clk);
      drive('{pk(1, 1, 1, 1), 4'd9, 1'b0, 1'b1, 1'b0});
      repeat (3) begin
         @(negedge clk);
         chk("R9 stall without tile", 32'(act_ready), 32'd0);
      end

      // R8/R2: swap waits for the load of tile A
      @(negedge clk);
      drive(TBL[0]);
      wq_valid = 1'b1;
      wq_row   = tile_row(0, 0);
      #1;
      chk("R8 stall before load", 32'(act_ready), 32'd0);
      for (int k = 1; k < N; k++) begin
         @(posedge clk);
         @(negedge clk);
         wq_row = tile_row(0, k);
         chk("R8 stall during load", 32'(act_ready), 32'd0);
      end
      @(posedge clk);
      @(negedge clk);
      wq_valid = 1'b0;
      chk("R2 N-1 rows loaded", 32'(act_ready), 32'd0);
      @(posedge clk);
      @(negedge clk);
      chk("R2 tile complete after N edges", 32'(act_ready), 32'd1);
      @(posedge clk);
      model_vec(TBL[0]);

      // table walk: batch one, then tile B, then batches two and three
      for (int idx = 1; idx < 10; idx++) begin
         if (idx == 6) begin
            idle(1);
            push_tile(1);
            idle(2);
         end
         send(TBL[idx], 1'b1);
      end
      idle(3);
      for (int a = 0; a < 6; a++) read_cmp("R4 R5 R7 table results", a);

      // R11 latency: result lands after the second edge
      send('{pk(1, 0, 0, 0), 4'd6, 1'b0, 1'b1, 1'b0}, 1'b1);
      @(negedge clk);
      act_valid = 1'b0;
      rd_addr   = 4'd6;
      #1;
      chk("R11 not yet written", rd_data[31:0], 32'd0);
      @(negedge clk);
      #1;
      chk("R11 written after second edge", rd_data[31:0], 32'hFFFF_FF80);

      // R6 wraparound: 32768 x 65536 reaches 2^31
      for (int k = 0; k < 32768; k++)
         send('{pk(-128, -128, -128, -128), 4'd7, (k != 0), (k == 32767), 1'b0}, 1'b0);
      idle(3);
      rd_addr = 4'd7;
      #1;
      chk("R6 wrap at 2^31", rd_data[31:0], 32'h8000_0000);
      send('{pk(-128, -128, -128, -128), 4'd7, 1'b1, 1'b1, 1'b0}, 1'b1);
      idle(3);
      rd_addr = 4'd7;
      #1;
      chk("R6 past wrap", rd_data[31:0], 32'h8001_0000);

      // R3 staging capacity: shadow empty, no swap pending
      begin
         int acc_cnt = 0;
         @(negedge clk);
         wq_valid = 1'b1;
         for (int k = 0; k < 40; k++) begin
            wq_row = 32'(k);
            #1;
            if (!wq_ready) break;
            acc_cnt++;
            @(negedge clk);
         end
         chk("R3 rows accepted", 32'(acc_cnt), 32'(5 * N));
         repeat (3) @(negedge clk);
         chk("R3 stays full", 32'(wq_ready), 32'd0);
         wq_valid = 1'b0;
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule